// File: doc/BRIEF.md
# USB Pipe Ping-Pong Buffer Controller

This block keeps the packet-buffer bookkeeping for one USB endpoint pipe. It sits between the serial engine, which deposits received packets or collects packets to send, and the CPU FIFO port, which drains or fills those packets one byte at a time. The pipe's storage lives in a shared buffer RAM. That RAM is carved into numbered 64-byte blocks. Depending on the pipe number and configuration, the pipe gets either one bank or two equal ping-pong banks. The block works out where the banks start and whether the layout fits. It records which banks hold a packet and how long each packet is, steers each side to its current bank, and answers every packet event with ACK or NAK.

A single control level gives two features. Held at 1 while the pipe receives, it makes the pipe swallow good packets: they are acknowledged but never stored. Lowering it again, after it has been high long enough, empties the pipe in either direction. If it is lowered too early, the block reports an error and keeps its contents.

Top module: `pipe_pingpong_ctl`

## Requirements
- R1: Pipe number 0 always maps to block 0 with a 4-block bank. Pipe 6 maps to block 4 and pipe 7 to block 5, each with a 1-block bank. These three pipes are always single-bank, so `bank1_blk` equals `bank0_blk`, whatever `cfg_dbl` says.
- R2: Pipes 1 to 5 start bank 0 at `cfg_base`. Each bank holds (`cfg_size`+1)×64 bytes. With `cfg_dbl`=1, bank 1 starts at `cfg_base`+`cfg_size`+1.
- R3: For pipes 1 to 5, `cfg_bad` is 1 when `cfg_base` is below 6, or when the last block used lies beyond block 127. While `cfg_bad` is 1, every good packet event gets NAK, no ACK is given, CPU strobes change nothing, and `cpu_ready` is 0.
- R4: In receive mode (`cfg_dir_tx`=0), a good packet (`sie_rx_valid`=1 with `sie_rx_ok`=1) is stored in the serial side's bank if that bank is empty and gets ACK one cycle later. It then shows on the CPU side as `cpu_ready`=1 with `cpu_len` equal to its byte count. If no bank is free, the packet gets NAK and its data is dropped.
- R5: The CPU reads packets in the order they arrived. Each `cpu_rd` advances `cpu_ptr`. The read that reaches the stored length frees the bank and moves the CPU to the other bank. For a zero-length packet, a single `cpu_rd` frees the bank.
- R6: A received packet flagged with an error (`sie_rx_ok`=0) gets neither ACK nor NAK and changes no bank.
- R7: In receive mode with `clr_ctl`=1, every good packet gets ACK and nothing is stored, so `cpu_ready` stays 0.
- R8: In transmit mode (`cfg_dir_tx`=1), `clr_ctl`=1 on its own discards nothing. Data the CPU writes and commits is still served to the serial side.
- R9: In transmit mode, each `cpu_wr` adds one byte to the CPU's empty bank. `cpu_commit`, or the write that reaches the bank size, marks the bank full with that count. A `sie_tx_req` on a full bank gets ACK with `sie_len` equal to the count and frees the bank. A `sie_tx_req` with no full bank gets NAK.
- R10: If `clr_ctl` is high for at least CLR_GAP consecutive cycles and then goes low, `clr_done` pulses. After that pulse both banks are empty, both sides point at bank 0 and `cpu_ptr` is 0, in either direction.
- R11: If `clr_ctl` goes low after fewer than CLR_GAP high cycles, `clr_err` pulses and the bank contents are kept.
- R12: With one bank, a second good packet gets NAK until the CPU has drained the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_pipe | input | 3 | Pipe number 0..7 |
| cfg_dir_tx | input | 1 | 0 receive (CPU reads), 1 transmit (CPU writes) |
| cfg_dbl | input | 1 | Request two banks (pipes 1..5 only) |
| cfg_base | input | 7 | First block of bank 0 for pipes 1..5 |
| cfg_size | input | 5 | Bank size in blocks minus one, pipes 1..5 |
| clr_ctl | input | 1 | Discard / clear control level |
| sie_rx_valid | input | 1 | Received packet event |
| sie_rx_ok | input | 1 | Received packet had no error |
| sie_rx_len | input | 12 | Received packet byte count |
| sie_tx_req | input | 1 | Serial side asks for a packet to send |
| sie_ack | output | 1 | ACK response, one cycle after the event |
| sie_nak | output | 1 | NAK response, one cycle after the event |
| sie_len | output | 12 | Byte count of the packet handed out with ACK in transmit mode |
| sie_bank_blk | output | 7 | Start block of the serial side's current bank |
| cpu_rd | input | 1 | CPU reads one byte |
| cpu_wr | input | 1 | CPU writes one byte |
| cpu_commit | input | 1 | CPU closes the current packet |
| cpu_ready | output | 1 | Receive: a packet waits; transmit: a bank is free to fill |
| cpu_len | output | 12 | Byte count stored in the CPU's current bank |
| cpu_ptr | output | 12 | Byte offset within the CPU's current bank |
| cpu_bank_blk | output | 7 | Start block of the CPU side's current bank |
| bank0_blk | output | 7 | Start block of bank 0 |
| bank1_blk | output | 7 | Start block of bank 1 (equals bank 0 when single) |
| cfg_bad | output | 1 | Configuration does not fit the buffer RAM |
| clr_done | output | 1 | Pulse: the pipe was cleared |
| clr_err | output | 1 | Pulse: clear refused, gap too short |

## Verification
The bench builds the block with 64-byte blocks, 128 blocks and a 5-bit size field, which are the defaults, but it sets CLR_GAP to 6. The short gap puts both sides of the clear timing rule within a few cycles: a 5-cycle hold must give the error and a 6-cycle hold the clear. The 5-bit size field lets a configuration starting at block 120 land exactly on block 127 with size 3, and overrun it with size 4. The one-block bank size used in the random receive phase keeps each drain under 65 reads, so several hundred mixed packet events fit in a short run.

// File: rtl/pp_pkg.sv
package pp_pkg;

    // Transfer direction seen from the CPU port.
    typedef enum logic {
        PP_RX = 1'b0,
        PP_TX = 1'b1
    } pp_dir_e;

    // Fixed block placement of the reserved pipes.
    localparam int PP_CTRL_BLKS = 4;
    localparam int PP_FIX6_BLK  = 4;
    localparam int PP_FIX7_BLK  = 5;

endpackage

// File: rtl/pp_alloc.sv
module pp_alloc #(
    parameter int NUM_BLK    = 128,
    parameter int USER_FIRST = 6,
    parameter int SIZE_W     = 5,
    localparam int BLK_W     = $clog2(NUM_BLK)
) (
    input  logic [2:0]        pipe,
    input  logic              dbl,
    input  logic [BLK_W-1:0]  base,
    input  logic [SIZE_W-1:0] size,
    output logic [BLK_W-1:0]  blk0,
    output logic [BLK_W-1:0]  blk1,
    output logic              eff_dbl,
    output logic [SIZE_W-1:0] eff_size,
    output logic              bad
);
    import pp_pkg::*;

    localparam int EW = BLK_W + SIZE_W + 2;

    logic [EW-1:0] span;
    logic [EW-1:0] last_excl;

    always_comb begin
        blk0     = '0;
        eff_dbl  = 1'b0;
        eff_size = '0;
        bad      = 1'b0;
        span     = '0;
        last_excl = '0;
        case (pipe)
            3'd0: begin
                blk0     = '0;
                eff_size = SIZE_W'(PP_CTRL_BLKS - 1);
            end
            3'd6: blk0 = BLK_W'(PP_FIX6_BLK);
            3'd7: blk0 = BLK_W'(PP_FIX7_BLK);
            default: begin
                blk0      = base;
                eff_dbl   = dbl;
                eff_size  = size;
                span      = EW'(size) + EW'(1);
                if (dbl) span = span << 1;
                last_excl = EW'(base) + span;
                bad       = (EW'(base) < EW'(USER_FIRST)) || (last_excl > EW'(NUM_BLK));
            end
        endcase
        blk1 = eff_dbl ? BLK_W'(blk0 + BLK_W'(eff_size) + BLK_W'(1)) : blk0;
    end
endmodule

// File: rtl/pp_clr.sv
module pp_clr #(
    parameter int CLR_GAP = 10,
    localparam int CW     = $clog2(CLR_GAP + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl,
    output logic fire,
    output logic err
);
    logic [CW-1:0] cnt_d, cnt_q;
    logic          fall;

    always_comb begin
        if (!ctl)                          cnt_d = '0;
        else if (cnt_q == CW'(CLR_GAP))    cnt_d = cnt_q;
        else                               cnt_d = cnt_q + CW'(1);
        fall = !ctl && (cnt_q != '0);
        fire = fall && (cnt_q == CW'(CLR_GAP));
        err  = fall && (cnt_q != CW'(CLR_GAP));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pipe_pingpong_ctl.sv
module pipe_pingpong_ctl #(
    parameter int BLK_BYTES  = 64,
    parameter int NUM_BLK    = 128,
    parameter int USER_FIRST = 6,
    parameter int SIZE_W     = 5,
    parameter int CLR_GAP    = 10,
    localparam int BLK_W     = $clog2(NUM_BLK),
    localparam int LEN_W     = $clog2(BLK_BYTES * (1 << SIZE_W) + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_pipe,
    input  logic              cfg_dir_tx,
    input  logic              cfg_dbl,
    input  logic [BLK_W-1:0]  cfg_base,
    input  logic [SIZE_W-1:0] cfg_size,
    input  logic              clr_ctl,
    input  logic              sie_rx_valid,
    input  logic              sie_rx_ok,
    input  logic [LEN_W-1:0]  sie_rx_len,
    input  logic              sie_tx_req,
    output logic              sie_ack,
    output logic              sie_nak,
    output logic [LEN_W-1:0]  sie_len,
    output logic [BLK_W-1:0]  sie_bank_blk,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic              cpu_commit,
    output logic              cpu_ready,
    output logic [LEN_W-1:0]  cpu_len,
    output logic [LEN_W-1:0]  cpu_ptr,
    output logic [BLK_W-1:0]  cpu_bank_blk,
    output logic [BLK_W-1:0]  bank0_blk,
    output logic [BLK_W-1:0]  bank1_blk,
    output logic              cfg_bad,
    output logic              clr_done,
    output logic              clr_err
);
    import pp_pkg::*;

    localparam int BLK_SH = $clog2(BLK_BYTES);

    typedef struct packed {
        logic [1:0]            full;
        logic [1:0][LEN_W-1:0] len;
        logic                  sie_sel;
        logic                  cpu_sel;
        logic [LEN_W-1:0]      ptr;
        logic                  ack;
        logic                  nak;
        logic [LEN_W-1:0]      slen;
        logic                  done;
        logic                  err;
    } st_t;

    st_t st_d, st_q;

    logic              eff_dbl;
    logic [SIZE_W-1:0] eff_size;
    logic [LEN_W-1:0]  bank_bytes;
    logic              clr_fire, clr_short;
    logic [LEN_W-1:0]  wr_cnt;
    logic [1:0]        full_vec;
    pp_dir_e           dir;

    assign dir = pp_dir_e'(cfg_dir_tx);

    pp_alloc #(
        .NUM_BLK   (NUM_BLK),
        .USER_FIRST(USER_FIRST),
        .SIZE_W    (SIZE_W)
    ) u_alloc (
        .pipe    (cfg_pipe),
        .dbl     (cfg_dbl),
        .base    (cfg_base),
        .size    (cfg_size),
        .blk0    (bank0_blk),
        .blk1    (bank1_blk),
        .eff_dbl (eff_dbl),
        .eff_size(eff_size),
        .bad     (cfg_bad)
    );

    pp_clr #(.CLR_GAP(CLR_GAP)) u_clr (
        .clk  (clk),
        .rst_n(rst_n),
        .ctl  (clr_ctl),
        .fire (clr_fire),
        .err  (clr_short)
    );

    assign bank_bytes = (LEN_W'(eff_size) + LEN_W'(1)) << BLK_SH;
    assign wr_cnt     = st_q.ptr + LEN_W'(cpu_wr);

    always_comb begin
        st_d      = st_q;
        st_d.ack  = 1'b0;
        st_d.nak  = 1'b0;
        st_d.done = 1'b0;
        st_d.err  = 1'b0;
        if (clr_fire) begin
            st_d.full    = '0;
            st_d.sie_sel = 1'b0;
            st_d.cpu_sel = 1'b0;
            st_d.ptr     = '0;
            st_d.done    = 1'b1;
        end else begin
            st_d.err = clr_short;
            if (cfg_bad) begin
                if ((dir == PP_RX && sie_rx_valid && sie_rx_ok) ||
                    (dir == PP_TX && sie_tx_req))
                    st_d.nak = 1'b1;
            end else if (dir == PP_RX) begin
                // serial side deposits into its bank
                if (sie_rx_valid && sie_rx_ok) begin
                    if (clr_ctl) begin
                        st_d.ack = 1'b1;
                    end else if (!st_q.full[st_q.sie_sel]) begin
                        st_d.full[st_q.sie_sel] = 1'b1;
                        st_d.len[st_q.sie_sel]  = sie_rx_len;
                        st_d.ack                = 1'b1;
                        st_d.sie_sel            = st_q.sie_sel ^ eff_dbl;
                    end else begin
                        st_d.nak = 1'b1;
                    end
                end
                // CPU side drains its bank
                if (cpu_rd && st_q.full[st_q.cpu_sel]) begin
                    if (st_q.ptr + LEN_W'(1) >= st_q.len[st_q.cpu_sel]) begin
                        st_d.full[st_q.cpu_sel] = 1'b0;
                        st_d.ptr                = '0;
                        st_d.cpu_sel            = st_q.cpu_sel ^ eff_dbl;
                    end else begin
                        st_d.ptr = st_q.ptr + LEN_W'(1);
                    end
                end
            end else begin
                // serial side collects a finished bank
                if (sie_tx_req) begin
                    if (st_q.full[st_q.sie_sel]) begin
                        st_d.full[st_q.sie_sel] = 1'b0;
                        st_d.ack                = 1'b1;
                        st_d.slen               = st_q.len[st_q.sie_sel];
                        st_d.sie_sel            = st_q.sie_sel ^ eff_dbl;
                    end else begin
                        st_d.nak = 1'b1;
                    end
                end
                // CPU side fills its bank
                if (!st_q.full[st_q.cpu_sel] && (cpu_wr || cpu_commit)) begin
                    if (cpu_commit || wr_cnt == bank_bytes) begin
                        st_d.full[st_q.cpu_sel] = 1'b1;
                        st_d.len[st_q.cpu_sel]  = wr_cnt;
                        st_d.ptr                = '0;
                        st_d.cpu_sel            = st_q.cpu_sel ^ eff_dbl;
                    end else begin
                        st_d.ptr = wr_cnt;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign full_vec     = st_q.full;
    assign sie_ack      = st_q.ack;
    assign sie_nak      = st_q.nak;
    assign sie_len      = st_q.slen;
    assign clr_done     = st_q.done;
    assign clr_err      = st_q.err;
    assign cpu_ptr      = st_q.ptr;
    assign cpu_len      = st_q.len[st_q.cpu_sel];
    assign cpu_ready    = !cfg_bad && ((dir == PP_TX) ? !st_q.full[st_q.cpu_sel]
                                                      :  st_q.full[st_q.cpu_sel]);
    assign sie_bank_blk = st_q.sie_sel ? bank1_blk : bank0_blk;
    assign cpu_bank_blk = st_q.cpu_sel ? bank1_blk : bank0_blk;
endmodule

// File: rtl/pp_chk.sv
module pp_chk #(
    parameter int LEN_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sie_ack,
    input logic             sie_nak,
    input logic             sie_rx_valid,
    input logic             sie_tx_req,
    input logic             cfg_bad,
    input logic             clr_done,
    input logic             clr_err,
    input logic [1:0]       full,
    input logic [LEN_W-1:0] cpu_ptr
);
    // R4: a single response per event
    assert_resp_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(sie_ack && sie_nak));

    // R4 / R9: responses only follow a packet event
    assert_resp_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sie_ack || sie_nak) |-> $past(sie_rx_valid || sie_tx_req));

    // R3: no ACK for an event seen under a bad layout
    assert_bad_no_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sie_ack |-> !$past(cfg_bad));

    // R10: a clear leaves everything empty
    assert_clear_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_done |-> (full == 2'b00 && cpu_ptr == '0));

    // R11: refusal and clear never coincide
    assert_done_err_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr_done && clr_err));
endmodule

bind pipe_pingpong_ctl pp_chk #(.LEN_W(LEN_W)) u_pp_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sie_ack     (sie_ack),
    .sie_nak     (sie_nak),
    .sie_rx_valid(sie_rx_valid),
    .sie_tx_req  (sie_tx_req),
    .cfg_bad     (cfg_bad),
    .clr_done    (clr_done),
    .clr_err     (clr_err),
    .full        (full_vec),
    .cpu_ptr     (cpu_ptr)
);

// File: tb/tb_pipe_pingpong_ctl.sv
module tb_pipe_pingpong_ctl;
    localparam int CLK_NS = 10;
    localparam int GAP    = 6;
    localparam int LW     = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] cfg_pipe = 3'd2;
    logic cfg_dir_tx = 1'b0, cfg_dbl = 1'b1;
    logic [6:0] cfg_base = 7'd6;
    logic [4:0] cfg_size = 5'd0;
    logic clr_ctl = 1'b0;
    logic sie_rx_valid = 1'b0, sie_rx_ok = 1'b0, sie_tx_req = 1'b0;
    logic [LW-1:0] sie_rx_len = '0;
    logic cpu_rd = 1'b0, cpu_wr = 1'b0, cpu_commit = 1'b0;
    logic sie_ack, sie_nak, cpu_ready, cfg_bad, clr_done, clr_err;
    logic [LW-1:0] sie_len, cpu_len, cpu_ptr;
    logic [6:0] sie_bank_blk, cpu_bank_blk, bank0_blk, bank1_blk;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_NS/2) clk = ~clk;

    pipe_pingpong_ctl #(.CLR_GAP(GAP)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_pipe(cfg_pipe), .cfg_dir_tx(cfg_dir_tx),
        .cfg_dbl(cfg_dbl), .cfg_base(cfg_base), .cfg_size(cfg_size), .clr_ctl(clr_ctl),
        .sie_rx_valid(sie_rx_valid), .sie_rx_ok(sie_rx_ok), .sie_rx_len(sie_rx_len),
        .sie_tx_req(sie_tx_req), .sie_ack(sie_ack), .sie_nak(sie_nak), .sie_len(sie_len),
        .sie_bank_blk(sie_bank_blk), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_commit(cpu_commit), .cpu_ready(cpu_ready), .cpu_len(cpu_len),
        .cpu_ptr(cpu_ptr), .cpu_bank_blk(cpu_bank_blk), .bank0_blk(bank0_blk),
        .bank1_blk(bank1_blk), .cfg_bad(cfg_bad), .clr_done(clr_done), .clr_err(clr_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // expected layout from the requirements
    function automatic void exp_alloc(input int pipe, input int dbl, input int base,
                                      input int size, output int b0, output int b1,
                                      output int bad);
        int nb;
        bad = 0;
        if (pipe == 0)      begin b0 = 0; b1 = 0; end
        else if (pipe == 6) begin b0 = 4; b1 = 4; end
        else if (pipe == 7) begin b0 = 5; b1 = 5; end
        else begin
            nb  = dbl ? 2 : 1;
            b0  = base;
            b1  = dbl ? base + size + 1 : base;
            bad = (base < 6 || base + nb * (size + 1) > 128) ? 1 : 0;
        end
    endfunction

    task automatic check_alloc(input string req, input int pipe, input int dbl,
                               input int base, input int size);
        int b0, b1, bad;
        cfg_pipe = 3'(pipe); cfg_dbl = dbl[0]; cfg_base = 7'(base); cfg_size = 5'(size);
        #1;
        exp_alloc(pipe, dbl, base, size, b0, b1, bad);
        chk({req, " bank0"}, int'(bank0_blk), b0);
        chk({req, " bank1"}, int'(bank1_blk), b1);
        chk({req, " bad"}, int'(cfg_bad), bad);
    endtask

    task automatic rx_pkt(input bit ok, input int len, output bit a, output bit n);
        sie_rx_valid = 1'b1; sie_rx_ok = ok; sie_rx_len = LW'(len);
        step();
        a = sie_ack; n = sie_nak;
        sie_rx_valid = 1'b0; sie_rx_ok = 1'b0;
    endtask

    task automatic tx_req(output bit a, output bit n, output int l);
        sie_tx_req = 1'b1;
        step();
        a = sie_ack; n = sie_nak; l = int'(sie_len);
        sie_tx_req = 1'b0;
    endtask

    task automatic do_clear(input string req, input int hold);
        clr_ctl = 1'b1;
        repeat (hold) step();
        clr_ctl = 1'b0;
        step();
        chk({req, " clr_done"}, int'(clr_done), hold >= GAP ? 1 : 0);
        chk({req, " clr_err"}, int'(clr_err), hold >= GAP ? 0 : 1);
    endtask

    // drain the CPU bank; n reads (one for an empty packet)
    task automatic drain(input int len);
        int n;
        n = (len == 0) ? 1 : len;
        cpu_rd = 1'b1;
        for (int k = 0; k < n; k++) begin
            step();
            if (k == 0 && n > 1) chk("R5 ptr after first read", int'(cpu_ptr), 1);
        end
        cpu_rd = 1'b0;
    endtask

    initial begin
        #(CLK_NS * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int q[$];
        bit a, n;
        int l, op, len;
        void'($urandom(32'd4242));

        repeat (3) step();
        rst_n = 1'b1;
        step();
        // reset state
        chk("R4 reset ready", int'(cpu_ready), 0);
        chk("R4 reset ack", int'(sie_ack), 0);
        chk("R10 reset ptr", int'(cpu_ptr), 0);

        // layout checks
        check_alloc("R1 pipe0", 0, 1, 50, 7);
        check_alloc("R1 pipe6", 6, 1, 50, 7);
        check_alloc("R1 pipe7", 7, 0, 9, 2);
        check_alloc("R2 pipe3 dbl", 3, 1, 10, 3);
        check_alloc("R2 pipe5 single", 5, 0, 40, 9);
        check_alloc("R3 base low", 1, 0, 5, 0);
        check_alloc("R3 exact end", 4, 1, 120, 3);
        check_alloc("R3 overrun", 4, 1, 120, 4);
        // bad layout: NAK and ignored CPU strobes
        rx_pkt(1'b1, 10, a, n);
        chk("R3 nak when bad", int'(n), 1);
        chk("R3 no ack when bad", int'(a), 0);
        chk("R3 ready when bad", int'(cpu_ready), 0);

        // random receive phase, two 64-byte banks
        check_alloc("R2 rx cfg", 2, 1, 6, 0);
        do_clear("R10 setup rx", GAP);
        for (int it = 0; it < 300; it++) begin
            op = int'($urandom % 5);
            if (op <= 1) begin
                len = int'($urandom % 65);
                rx_pkt(1'b1, len, a, n);
                if (q.size() < 2) begin
                    chk("R4 ack free bank", int'(a), 1);
                    q.push_back(len);
                end else begin
                    chk("R4 nak both full", int'(n), 1);
                end
            end else if (op == 2) begin
                rx_pkt(1'b0, 7, a, n);
                chk("R6 bad pkt ack", int'(a), 0);
                chk("R6 bad pkt nak", int'(n), 0);
            end else if (q.size() > 0) begin
                chk("R5 len in order", int'(cpu_len), q[0]);
                drain(q[0]);
                void'(q.pop_front());
            end
            chk("R4 ready", int'(cpu_ready), q.size() > 0 ? 1 : 0);
            if (q.size() > 0) chk("R5 front len", int'(cpu_len), q[0]);
        end

        // R11: too short a hold keeps data
        while (q.size() < 2) begin
            rx_pkt(1'b1, 20, a, n);
            q.push_back(20);
        end
        do_clear("R11 short", GAP - 1);
        chk("R11 data kept", int'(cpu_ready), 1);
        chk("R11 len kept", int'(cpu_len), q[0]);
        // R10: full clear
        do_clear("R10 full", GAP);
        chk("R10 empty", int'(cpu_ready), 0);
        chk("R10 sie bank0", int'(sie_bank_blk), 6);
        chk("R10 cpu bank0", int'(cpu_bank_blk), 6);
        q.delete();

        // R12: single bank
        cfg_dbl = 1'b0;
        do_clear("R10 setup single", GAP);
        rx_pkt(1'b1, 3, a, n);
        chk("R12 first ack", int'(a), 1);
        rx_pkt(1'b1, 4, a, n);
        chk("R12 second nak", int'(n), 1);
        drain(3);
        rx_pkt(1'b1, 4, a, n);
        chk("R12 ack after drain", int'(a), 1);
        chk("R12 len", int'(cpu_len), 4);
        drain(4);

        // R7: discard while receiving
        cfg_dbl = 1'b1;
        do_clear("R10 setup discard", GAP);
        clr_ctl = 1'b1;
        rx_pkt(1'b1, 9, a, n);
        chk("R7 discard ack", int'(a), 1);
        rx_pkt(1'b1, 0, a, n);
        chk("R7 discard ack2", int'(a), 1);
        chk("R7 nothing stored", int'(cpu_ready), 0);
        repeat (GAP) step();
        clr_ctl = 1'b0;
        step();
        chk("R10 after discard", int'(clr_done), 1);

        // transmit: R9
        cfg_dir_tx = 1'b1;
        cfg_size = 5'd1;
        do_clear("R10 setup tx", GAP);
        chk("R9 writable", int'(cpu_ready), 1);
        tx_req(a, n, l);
        chk("R9 nak empty", int'(n), 1);
        cpu_wr = 1'b1;
        repeat (5) step();
        cpu_wr = 1'b0;
        cpu_commit = 1'b1;
        step();
        cpu_commit = 1'b0;
        chk("R9 other bank free", int'(cpu_ready), 1);
        cpu_wr = 1'b1;
        repeat (128) step();
        cpu_wr = 1'b0;
        chk("R9 both full", int'(cpu_ready), 0);
        tx_req(a, n, l);
        chk("R9 ack first", int'(a), 1);
        chk("R9 len first", l, 5);
        tx_req(a, n, l);
        chk("R9 len full bank", l, 128);
        tx_req(a, n, l);
        chk("R9 nak drained", int'(n), 1);

        // R8: control level does not discard in transmit
        clr_ctl = 1'b1;
        cpu_wr = 1'b1;
        repeat (2) step();
        cpu_wr = 1'b0;
        cpu_commit = 1'b1;
        step();
        cpu_commit = 1'b0;
        tx_req(a, n, l);
        chk("R8 served ack", int'(a), 1);
        chk("R8 served len", l, 2);
        repeat (GAP) step();
        clr_ctl = 1'b0;
        step();
        chk("R10 tx clear", int'(clr_done), 1);
        chk("R10 tx writable", int'(cpu_ready), 1);

        summary();
    end
endmodule